// File: doc/BRIEF.md
# Dual-Channel Current Fault Detector

This block compares two unsigned current magnitude words, one from the phase conductor (channel A) and one from the return conductor (channel B). If they disagree by more than one sixteenth of the larger value, a fault is reported. The fault is reported only after the disagreement has lasted for a set number of sample strobes. The block always passes the larger of the two words downstream. Metering therefore stays correct when current leaks past one of the sensors.

All decisions are taken on a sample strobe and held in registers until the next strobe. The channel index, the magnitude word and the fault flag therefore change together, one cycle after the strobe. At light load the fault logic is switched off. The light-load threshold is about 0.3% of a full-scale constant supplied at an input.

Top module: `cur_fault_det`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, `sel_b` is 0 (channel A), `mag_out` is 0 and `fault` is 0.
- R2: On each strobe, `sel_b` becomes 1 when `mag_b` is strictly greater than `mag_a`, and 0 otherwise; a tie selects channel A.
- R3: On each strobe, `mag_out` takes the word of the channel that R2 selects, from the same strobe. In effect it is the larger of the two words.
- R4: `sel_b`, `mag_out` and `fault` are updated in the clock cycle after a strobe and hold their values at all other times, whatever the magnitude inputs do.
- R5: A strobe sees a mismatch when (larger − smaller) > (larger >> 4). A difference exactly equal to larger >> 4 is not a mismatch.
- R6: A strobe is "active" when it sees a mismatch and light load (R8) does not apply. `fault` rises in the cycle after the PERSIST-th consecutive active strobe and stays high while strobes stay active.
- R7: A strobe that is not active resets the persistence count to zero and clears `fault` in the following cycle. A later fault again needs PERSIST consecutive active strobes.
- R8: Light load applies when the larger word is below (fs >> 9) + (fs >> 10) + (fs >> 12), where fs is `full_scale` (about 0.32%). A light-load strobe is never active, whatever the mismatch.
- R9: While `fault` is high, `mag_out` still follows the larger channel on every strobe, including when the larger channel changes from A to B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe; inputs are evaluated when high |
| mag_a | input | MAG_W | Phase channel magnitude |
| mag_b | input | MAG_W | Return channel magnitude |
| full_scale | input | MAG_W | Full-scale magnitude used for the light-load threshold |
| sel_b | output | 1 | Selected channel: 0 = A, 1 = B |
| mag_out | output | MAG_W | Magnitude of the selected channel |
| fault | output | 1 | Persistent mismatch flag |

## Verification
The bench builds the block with MAG_W = 16 and PERSIST = 4. At the default persistence of about a second of strobes, a fault could not be raised, interrupted and raised again within a short run. With a count of four, the bench reaches the exact strobe on which `fault` rises, the restart after a single quiet strobe, and the clearing by light load. `full_scale` is 16'hFFFF, which puts the light-load threshold at 205. Words on either side of that threshold, and on either side of the one-sixteenth boundary, can then be chosen by hand.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } ch_e;

    // Amounts by which full scale is shifted; the terms are summed to form the light-load limit.
    localparam int LL_NTERM = 3;
    localparam int LL_SHIFT [LL_NTERM] = '{9, 10, 12};

endpackage

// File: rtl/cfd_compare.sv
module cfd_compare #(
    parameter int W     = 16,
    parameter int SHIFT = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output cfd_pkg::ch_e win_o,
    output logic [W-1:0] big_o,
    output logic         mismatch_o
);
    import cfd_pkg::*;

    logic [W-1:0] small_w;
    logic [W-1:0] diff_w;
    logic [W-1:0] tol_w;

    always_comb begin
        if (b_i > a_i) begin
            win_o   = CH_B;
            big_o   = b_i;
            small_w = a_i;
        end else begin
            win_o   = CH_A;
            big_o   = a_i;
            small_w = b_i;
        end
        diff_w     = big_o - small_w;
        tol_w      = big_o >> SHIFT;
        mismatch_o = diff_w > tol_w;
    end

endmodule

// File: rtl/cfd_lightload.sv
module cfd_lightload #(
    parameter int W = 16
) (
    input  logic [W-1:0] big_i,
    input  logic [W-1:0] fs_i,
    output logic         light_o
);
    import cfd_pkg::*;

    localparam int SW = W + 2;

    logic [SW-1:0] term_w [LL_NTERM];
    logic [SW-1:0] limit_w;

    for (genvar g = 0; g < LL_NTERM; g++) begin : g_term
        assign term_w[g] = SW'(fs_i >> LL_SHIFT[g]);
    end

    always_comb begin
        limit_w = '0;
        for (int k = 0; k < LL_NTERM; k++) begin
            limit_w = limit_w + term_w[k];
        end
        light_o = SW'(big_i) < limit_w;
    end

endmodule

// File: rtl/cfd_persist.sv
module cfd_persist #(
    parameter int PERSIST = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic active_i,
    output logic fault_o
);
    localparam int CNT_W = $clog2(PERSIST + 1);
    localparam logic [CNT_W-1:0] LIM  = CNT_W'(PERSIST);
    localparam logic [CNT_W-1:0] LIM1 = CNT_W'(PERSIST - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fault;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb_i) begin
            if (active_i) begin
                if (st_q.cnt != LIM) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                st_d.fault = st_q.cnt >= LIM1;
            end else begin
                st_d.cnt   = '0;
                st_d.fault = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_o = st_q.fault;

endmodule

// File: rtl/cur_fault_det.sv
module cur_fault_det #(
    parameter int MAG_W   = 16,
    parameter int PERSIST = 4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    input  logic [MAG_W-1:0] full_scale,
    output logic             sel_b,
    output logic [MAG_W-1:0] mag_out,
    output logic             fault
);
    import cfd_pkg::*;

    localparam int TOL_SHIFT = 4;

    typedef struct packed {
        ch_e              sel;
        logic [MAG_W-1:0] mag;
    } out_t;

    out_t             out_d, out_q;
    ch_e              win_w;
    logic [MAG_W-1:0] big_w;
    logic             mism_w;
    logic             light_w;
    logic             active_w;

    cfd_compare #(.W(MAG_W), .SHIFT(TOL_SHIFT)) u_cmp (
        .a_i        (mag_a),
        .b_i        (mag_b),
        .win_o      (win_w),
        .big_o      (big_w),
        .mismatch_o (mism_w)
    );

    cfd_lightload #(.W(MAG_W)) u_ll (
        .big_i   (big_w),
        .fs_i    (full_scale),
        .light_o (light_w)
    );

    assign active_w = mism_w && !light_w;

    cfd_persist #(.PERSIST(PERSIST)) u_pst (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_i    (smp_stb),
        .active_i (active_w),
        .fault_o  (fault)
    );

    always_comb begin
        out_d = out_q;
        if (smp_stb) begin
            out_d.sel = win_w;
            out_d.mag = big_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '{sel: CH_A, mag: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign sel_b   = (out_q.sel == CH_B);
    assign mag_out = out_q.mag;

endmodule

// File: rtl/cfd_chk.sv
module cfd_chk #(
    parameter int MAG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_stb,
    input logic [MAG_W-1:0] mag_a,
    input logic [MAG_W-1:0] mag_b,
    input logic             sel_b,
    input logic [MAG_W-1:0] mag_out,
    input logic             fault
);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> ($stable(sel_b) && $stable(mag_out) && $stable(fault)));

    p_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> (sel_b == ($past(mag_b) > $past(mag_a))));

    p_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> (mag_out == (sel_b ? $past(mag_b) : $past(mag_a))));

    p_larger_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> (mag_out >= $past(mag_a) && mag_out >= $past(mag_b)));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && mag_a == mag_b) |=> !fault);

    p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(smp_stb));

endmodule

bind cur_fault_det cfd_chk #(.MAG_W(MAG_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_stb (smp_stb),
    .mag_a   (mag_a),
    .mag_b   (mag_b),
    .sel_b   (sel_b),
    .mag_out (mag_out),
    .fault   (fault)
);

// File: tb/sim_cur_fault_det.sv
module sim_cur_fault_det;

    localparam int W = 16;
    localparam int P = 4;
    localparam logic [W-1:0] FS = 16'hFFFF;

    typedef struct {
        logic         sel;
        logic [W-1:0] mag;
        logic         flt;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         smp_stb = 1'b0;
    logic [W-1:0] mag_a = '0;
    logic [W-1:0] mag_b = '0;
    logic [W-1:0] full_scale = FS;
    logic         sel_b;
    logic [W-1:0] mag_out;
    logic         fault;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t q[$];
    int   m_cnt = 0;
    exp_t m_cur = '{sel: 1'b0, mag: '0, flt: 1'b0, req: "R1"};

    always #10 clk = ~clk;

    cur_fault_det #(.MAG_W(W), .PERSIST(P)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .mag_a(mag_a),
        .mag_b(mag_b), .full_scale(full_scale), .sel_b(sel_b),
        .mag_out(mag_out), .fault(fault)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic step(input logic stb, input logic [W-1:0] a, input logic [W-1:0] b,
                        input string req);
        logic [W-1:0] big, sml, thr;
        logic act;
        @(negedge clk);
        smp_stb = stb; mag_a = a; mag_b = b;
        if (stb) begin
            big = (b > a) ? b : a;
            sml = (b > a) ? a : b;
            thr = (FS >> 9) + (FS >> 10) + (FS >> 12);
            act = ((big - sml) > (big >> 4)) && !(big < thr);
            if (act) m_cnt = (m_cnt < P) ? m_cnt + 1 : m_cnt;
            else     m_cnt = 0;
            m_cur.sel = (b > a);
            m_cur.mag = big;
            m_cur.flt = act && (m_cnt >= P);
        end
        m_cur.req = req;
        @(posedge clk);
        #1 q.push_back(m_cur);
    endtask

    // monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.req, " sel"},   W'(sel_b), W'(e.sel));
            check({e.req, " mag"},   mag_out,   e.mag);
            check({e.req, " fault"}, W'(fault), W'(e.flt));
        end
    end

    initial begin
        #5000000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        mag_a = 16'd3000; mag_b = 16'd9000;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 sel", W'(sel_b), '0);
        check("R1 mag", mag_out, '0);
        check("R1 fault", W'(fault), '0);
        @(negedge clk);
        rst_n = 1'b1;
        mag_a = '0; mag_b = '0;

        step(1, 16'd1000, 16'd1000, "R2");    // tie keeps A
        step(1, 16'd1000, 16'd1050, "R2");    // B larger, within tolerance
        step(0, 16'd5000, 16'd100,  "R4");    // no strobe: hold
        step(0, 16'd7,    16'd9999, "R4");
        step(1, 16'd1600, 16'd1500, "R5");    // diff equals larger>>4: no mismatch
        step(1, 16'd1600, 16'd1499, "R5");    // one past the boundary: count 1
        step(1, 16'd1600, 16'd1499, "R6");    // count 2
        step(1, 16'd1600, 16'd1499, "R6");    // count 3
        step(1, 16'd1600, 16'd1499, "R6");    // count 4: fault rises
        step(0, 16'd1600, 16'd1600, "R4");    // fault held without strobe
        step(1, 16'd100,  16'd2000, "R9");    // B now larger, fault stays
        step(1, 16'd1000, 16'd1000, "R7");    // quiet strobe clears
        step(1, 16'd2000, 16'd100,  "R7");    // restart: count 1
        step(1, 16'd2000, 16'd100,  "R7");
        step(1, 16'd2000, 16'd100,  "R7");
        step(1, 16'd2000, 16'd1990, "R7");    // break at count 3
        for (int i = 0; i < 4; i++) step(1, 16'd100, 16'd3000, "R6");
        step(1, 16'd200,  16'd10,   "R8");    // light load clears fault
        for (int i = 0; i < 5; i++) step(1, 16'd204, 16'd10, "R8");
        for (int i = 0; i < 4; i++) step(1, 16'd10, 16'd205, "R8"); // at threshold: active
        step(1, 16'd4000, 16'd3000, "R3");
        step(1, 16'd3000, 16'd4001, "R3");
        step(0, 16'd0,    16'd0,    "R4");
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule